// File: doc/BRIEF.md
# Type-1 Bridge Configuration Header

This block holds the configuration header that a downstream port presents to system software as a PCI-to-PCI bridge. A configuration agent issues one request per cycle: a dword index, a write flag, four byte enables and right-aligned write data. One cycle later the block answers with right-aligned read data and an error flag. Accesses of one, two or four bytes are accepted. A narrow write is merged into the stored dword. A narrow read returns only the selected bytes, shifted down to bit 0.

The fields that steer forwarding are turned into hardware windows. These are the I/O base and limit with their upper 16 bits, and the memory base and limit. Each window has a valid flag and inclusive base and end addresses. The windows are re-evaluated only when software writes one of their source dwords. The programmed secondary bus number is driven out continuously so that the link logic can claim type-0 configuration cycles for its own bus.

Top module: `bridge_cfg_header`

## Requirements
- R1: After reset the header reads as follows. Dword 0 is {device 7846h, vendor parameter}. Dword 1 is 0010_0000h, which is the capability-list status bit. Dword 2 is 0604_0000h (bridge class, revision 0). Dword 3 is 0001_0010h (header type 01h, cache line 10h). Dword 7 is 0000_0101h. Every other implemented dword reads zero. Both windows are invalid and the secondary bus is 0.
- R2: Bit 0 of the I/O base byte (dword 7, byte 0) and bit 0 of the I/O limit byte (dword 7, byte 1) always read 1, whatever was written.
- R3: The legal byte-enable patterns are 1111, 0001, 0010, 0100, 1000, 0011, 0110 and 1100. The lane is the lowest enabled byte. A write replaces only the enabled bytes. Any other pattern returns the error flag and changes nothing.
- R4: A read of an unimplemented dword returns FFFF_FFFFh with the error flag set. The unimplemented dwords are index 13, index 15 and all indexes of 16 and above. The expansion ROM dword (index 14) reads zero. A write to an unimplemented dword changes nothing and completes without error.
- R5: A 1- or 2-byte read returns the dword shifted right by 8 × lane and masked to the access width.
- R6: The I/O window is invalid when limit byte < base byte or when upper limit < upper base. Otherwise its base is {upper base, base[7:4], 000h} and its end is {upper limit, limit[7:4], FFFh}. The base and limit bytes are in dword 7, bytes 0 and 1. The upper base and upper limit are in dword 12, low and high halves.
- R7: The memory window is invalid when the limit half (dword 8 high) is below the base half (dword 8 low). Otherwise its base is {base[15:4], 00000h} and its end is {limit[15:4], FFFFFh}.
- R8: The secondary bus output equals byte 1 of dword 6, and it follows every accepted write to that byte.
- R9: A window changes only on the second clock edge after an accepted write to one of its source dwords: dwords 7 and 12 for I/O, dword 8 for memory. Writes to any other dword leave both windows unchanged.
- R10: Dwords 0, 2, 3 and 14 ignore writes.
- R11: Every request produces exactly one response, on the clock edge that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgValid | input | 1 | Request strobe |
| cfgWe | input | 1 | 1 = write, 0 = read |
| cfgDwAddr | input | DW_ADDR_W | Dword index (byte offset / 4) |
| cfgByteEn | input | 4 | Byte enables |
| cfgWdata | input | 32 | Write data, right-aligned |
| rspValid | output | 1 | Response strobe, one cycle after request |
| rspErr | output | 1 | Rejected size or unimplemented read |
| rspData | output | 32 | Read data, right-aligned |
| secBus | output | 8 | Programmed secondary bus number |
| ioWinValid | output | 1 | I/O window enabled |
| ioWinBase | output | 32 | I/O window first address |
| ioWinEnd | output | 32 | I/O window last address |
| memWinValid | output | 1 | Memory window enabled |
| memWinBase | output | 32 | Memory window first address |
| memWinEnd | output | 32 | Memory window last address |

## Verification
The bench targets the upper-16 comparison for I/O: a window whose low bytes are ordered but whose upper halves are reversed must be disabled. A design that compared only the low bytes would keep forwarding a bogus range. It writes zeros into the I/O base dword so that a design that let the type bit be cleared would report bit 0 as 0. It also issues narrow writes at lanes 1 to 3 and illegal enable patterns. A wrong shift or a missing reject would corrupt neighbouring fields, such as the secondary bus. The window outputs are sampled one edge after each write and again one edge later. This shows up a design that updates them too early or on unrelated writes.

// File: rtl/bridge_cfg_pkg.sv
package bridge_cfg_pkg;

  localparam int NUM_DW  = 16;
  localparam int DW_ID   = 0;
  localparam int DW_CMD  = 1;
  localparam int DW_CLS  = 2;
  localparam int DW_HDR  = 3;
  localparam int DW_BUS  = 6;
  localparam int DW_IO   = 7;
  localparam int DW_MEM  = 8;
  localparam int DW_IOUP = 12;
  localparam int DW_ROM  = 14;

  // Dwords that answer reads (13 and 15 are holes).
  localparam logic [NUM_DW-1:0] IMPL_MASK = 16'h5FFF;
  // Dwords that hold software-writable state.
  localparam logic [NUM_DW-1:0] WR_MASK   = 16'h1FF2;

  localparam logic [31:0] IO_TYPE_BITS = 32'h0000_0101;

  typedef struct packed {
    logic        reqValid;
    logic        reqWrite;
    logic        reqErr;
    logic        wrEn;
    logic [3:0]  dwIdx;
    logic [1:0]  lane;
    logic [31:0] widthMask;
    logic        ioEval;
    logic        memEval;
  } bridgeStrobes_t;

endpackage

// File: rtl/bridge_cfg_ctrl.sv
module bridge_cfg_ctrl
  import bridge_cfg_pkg::*;
#(
  parameter int DW_ADDR_W = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgValid,
  input  logic                 cfgWe,
  input  logic [DW_ADDR_W-1:0] cfgDwAddr,
  input  logic [3:0]           cfgByteEn,
  output bridgeStrobes_t       strobes
);

  logic        sizeOk;
  logic [1:0]  lane;
  logic [31:0] widthMask;
  logic        inRange;
  logic        hit;
  logic [3:0]  idx;
  logic        wrFire;
  logic        ioEvalQ;
  logic        memEvalQ;

  always_comb begin
    sizeOk    = 1'b1;
    lane      = 2'd0;
    widthMask = 32'hFFFF_FFFF;
    unique case (cfgByteEn)
      4'b1111: ;
      4'b0001: widthMask = 32'h0000_00FF;
      4'b0010: begin lane = 2'd1; widthMask = 32'h0000_00FF; end
      4'b0100: begin lane = 2'd2; widthMask = 32'h0000_00FF; end
      4'b1000: begin lane = 2'd3; widthMask = 32'h0000_00FF; end
      4'b0011: widthMask = 32'h0000_FFFF;
      4'b0110: begin lane = 2'd1; widthMask = 32'h0000_FFFF; end
      4'b1100: begin lane = 2'd2; widthMask = 32'h0000_FFFF; end
      default: sizeOk = 1'b0;
    endcase
  end

  assign inRange = (cfgDwAddr < DW_ADDR_W'(NUM_DW));
  assign idx     = cfgDwAddr[3:0];
  assign hit     = inRange && IMPL_MASK[idx];
  assign wrFire  = cfgValid && cfgWe && sizeOk && hit && WR_MASK[idx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ioEvalQ  <= 1'b0;
      memEvalQ <= 1'b0;
    end else begin
      ioEvalQ  <= wrFire && (idx == 4'(DW_IO) || idx == 4'(DW_IOUP));
      memEvalQ <= wrFire && (idx == 4'(DW_MEM));
    end
  end

  always_comb begin
    strobes.reqValid  = cfgValid;
    strobes.reqWrite  = cfgWe;
    strobes.reqErr    = !sizeOk || (!cfgWe && !hit);
    strobes.wrEn      = wrFire;
    strobes.dwIdx     = idx;
    strobes.lane      = lane;
    strobes.widthMask = widthMask;
    strobes.ioEval    = ioEvalQ;
    strobes.memEval   = memEvalQ;
  end

  // R9: a re-evaluation strobe always traces back to a write request
  p_eval_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ioEval || strobes.memEval) |-> $past(cfgValid && cfgWe));

endmodule

// File: rtl/bridge_cfg_datapath.sv
module bridge_cfg_datapath
  import bridge_cfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'hABCD,
  parameter logic [15:0] DEVICE_ID  = 16'h7846,
  parameter logic [7:0]  REVISION   = 8'h00,
  parameter logic [7:0]  CACHE_LINE = 8'h10
) (
  input  logic           clk,
  input  logic           rstN,
  input  bridgeStrobes_t strobes,
  input  logic [31:0]    cfgWdata,
  output logic           rspValid,
  output logic           rspErr,
  output logic [31:0]    rspData,
  output logic [7:0]     secBus,
  output logic           ioWinValid,
  output logic [31:0]    ioWinBase,
  output logic [31:0]    ioWinEnd,
  output logic           memWinValid,
  output logic [31:0]    memWinBase,
  output logic [31:0]    memWinEnd
);

  localparam logic [31:0] ID_VAL   = {DEVICE_ID, VENDOR_ID};
  localparam logic [31:0] CLS_VAL  = {24'h060400, REVISION};
  localparam logic [31:0] HDR_VAL  = {8'h00, 8'h01, 8'h00, CACHE_LINE};
  localparam logic [31:0] CMD_RST  = 32'h0010_0000;

  function automatic logic [31:0] fixedVal(input int i);
    case (i)
      DW_ID:   return ID_VAL;
      DW_CLS:  return CLS_VAL;
      DW_HDR:  return HDR_VAL;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] resetVal(input int i);
    case (i)
      DW_CMD:  return CMD_RST;
      DW_IO:   return IO_TYPE_BITS;
      default: return 32'h0;
    endcase
  endfunction

  logic [31:0] dw [NUM_DW];
  logic [4:0]  shiftAmt;
  logic [31:0] byteMask;
  logic [31:0] curDw;
  logic [31:0] mergedDw;
  logic [31:0] rdShifted;

  assign shiftAmt  = {strobes.lane, 3'b000};
  assign byteMask  = strobes.widthMask << shiftAmt;
  assign curDw     = dw[strobes.dwIdx];
  assign mergedDw  = (curDw & ~byteMask) | (((cfgWdata & strobes.widthMask) << shiftAmt) & byteMask);
  assign rdShifted = (curDw >> shiftAmt) & strobes.widthMask;

  for (genvar gi = 0; gi < NUM_DW; gi++) begin : g_dw
    if (WR_MASK[gi]) begin : g_rw
      always_ff @(posedge clk) begin
        if (!rstN) begin
          dw[gi] <= resetVal(gi);
        end else if (strobes.wrEn && strobes.dwIdx == 4'(gi)) begin
          dw[gi] <= (gi == DW_IO) ? (mergedDw | IO_TYPE_BITS) : mergedDw;
        end
      end
    end else begin : g_ro
      assign dw[gi] = fixedVal(gi);
    end
  end

  assign secBus = dw[DW_BUS][15:8];

  logic ioBad;
  logic memBad;
  assign ioBad  = (dw[DW_IO][15:8] < dw[DW_IO][7:0]) ||
                  (dw[DW_IOUP][31:16] < dw[DW_IOUP][15:0]);
  assign memBad = dw[DW_MEM][31:16] < dw[DW_MEM][15:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ioWinValid  <= 1'b0;
      ioWinBase   <= '0;
      ioWinEnd    <= '0;
      memWinValid <= 1'b0;
      memWinBase  <= '0;
      memWinEnd   <= '0;
    end else begin
      if (strobes.ioEval) begin
        ioWinValid <= !ioBad;
        ioWinBase  <= ioBad ? 32'h0 : {dw[DW_IOUP][15:0], dw[DW_IO][7:4], 12'h000};
        ioWinEnd   <= ioBad ? 32'h0 : {dw[DW_IOUP][31:16], dw[DW_IO][15:12], 12'hFFF};
      end
      if (strobes.memEval) begin
        memWinValid <= !memBad;
        memWinBase  <= memBad ? 32'h0 : {dw[DW_MEM][15:4], 20'h00000};
        memWinEnd   <= memBad ? 32'h0 : {dw[DW_MEM][31:20], 20'hFFFFF};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strobes.reqValid;
      if (strobes.reqValid) begin
        rspErr  <= strobes.reqErr;
        rspData <= strobes.reqErr ? 32'hFFFF_FFFF :
                   (strobes.reqWrite ? 32'h0 : rdShifted);
      end
    end
  end

  p_io_type_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspErr && $past(strobes.reqValid && !strobes.reqWrite &&
      strobes.dwIdx == 4'(DW_IO) && strobes.lane == 2'd0)) |-> rspData[0]);

  p_err_ones_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspErr && $past(!strobes.reqWrite)) |-> rspData == 32'hFFFF_FFFF);

  p_io_order_r6: assert property (@(posedge clk) disable iff (!rstN)
    ioWinValid |-> ioWinEnd > ioWinBase);

  p_mem_order_r7: assert property (@(posedge clk) disable iff (!rstN)
    memWinValid |-> memWinEnd > memWinBase);

  p_io_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.ioEval) |-> ($stable(ioWinValid) && $stable(ioWinBase) && $stable(ioWinEnd)));

  p_mem_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.memEval) |-> ($stable(memWinValid) && $stable(memWinBase) && $stable(memWinEnd)));

endmodule

// File: rtl/bridge_cfg_header.sv
module bridge_cfg_header
  import bridge_cfg_pkg::*;
#(
  parameter int          DW_ADDR_W = 6,
  parameter logic [15:0] VENDOR_ID = 16'hABCD,
  parameter logic [15:0] DEVICE_ID = 16'h7846
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgValid,
  input  logic                 cfgWe,
  input  logic [DW_ADDR_W-1:0] cfgDwAddr,
  input  logic [3:0]           cfgByteEn,
  input  logic [31:0]          cfgWdata,
  output logic                 rspValid,
  output logic                 rspErr,
  output logic [31:0]          rspData,
  output logic [7:0]           secBus,
  output logic                 ioWinValid,
  output logic [31:0]          ioWinBase,
  output logic [31:0]          ioWinEnd,
  output logic                 memWinValid,
  output logic [31:0]          memWinBase,
  output logic [31:0]          memWinEnd
);

  bridgeStrobes_t strobes;

  bridge_cfg_ctrl #(.DW_ADDR_W(DW_ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgValid  (cfgValid),
    .cfgWe     (cfgWe),
    .cfgDwAddr (cfgDwAddr),
    .cfgByteEn (cfgByteEn),
    .strobes   (strobes)
  );

  bridge_cfg_datapath #(.VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .cfgWdata    (cfgWdata),
    .rspValid    (rspValid),
    .rspErr      (rspErr),
    .rspData     (rspData),
    .secBus      (secBus),
    .ioWinValid  (ioWinValid),
    .ioWinBase   (ioWinBase),
    .ioWinEnd    (ioWinEnd),
    .memWinValid (memWinValid),
    .memWinBase  (memWinBase),
    .memWinEnd   (memWinEnd)
  );

  p_rsp_timing_r11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid == $past(cfgValid));

endmodule

// File: tb/test_bridge_cfg_header.sv
module test_bridge_cfg_header;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgValid = 1'b0;
  logic        cfgWe = 1'b0;
  logic [5:0]  cfgDwAddr = '0;
  logic [3:0]  cfgByteEn = '0;
  logic [31:0] cfgWdata = '0;
  logic        rspValid, rspErr;
  logic [31:0] rspData;
  logic [7:0]  secBus;
  logic        ioWinValid, memWinValid;
  logic [31:0] ioWinBase, ioWinEnd, memWinBase, memWinEnd;

  always #4 clk = ~clk;

  bridge_cfg_header i_bridge_cfg_header (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgWe(cfgWe),
    .cfgDwAddr(cfgDwAddr), .cfgByteEn(cfgByteEn), .cfgWdata(cfgWdata),
    .rspValid(rspValid), .rspErr(rspErr), .rspData(rspData), .secBus(secBus),
    .ioWinValid(ioWinValid), .ioWinBase(ioWinBase), .ioWinEnd(ioWinEnd),
    .memWinValid(memWinValid), .memWinBase(memWinBase), .memWinEnd(memWinEnd)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] m [16];
  logic        mIoV, mMemV;
  logic [31:0] mIoB, mIoE, mMemB, mMemE;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit legalBe(input logic [3:0] be, output int lane, output logic [31:0] wm);
    lane = 0; wm = 32'hFFFF_FFFF;
    case (be)
      4'b1111: return 1'b1;
      4'b0001: begin wm = 32'hFF; return 1'b1; end
      4'b0010: begin lane = 1; wm = 32'hFF; return 1'b1; end
      4'b0100: begin lane = 2; wm = 32'hFF; return 1'b1; end
      4'b1000: begin lane = 3; wm = 32'hFF; return 1'b1; end
      4'b0011: begin wm = 32'hFFFF; return 1'b1; end
      4'b0110: begin lane = 1; wm = 32'hFFFF; return 1'b1; end
      4'b1100: begin lane = 2; wm = 32'hFFFF; return 1'b1; end
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit implIdx(input int i);
    return (i < 16) && (i != 13) && (i != 15);
  endfunction

  function automatic bit writableIdx(input int i);
    return (i == 1) || (i >= 4 && i <= 12);
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 16; i++) m[i] = 32'h0;
    m[0] = 32'h7846_ABCD;
    m[1] = 32'h0010_0000;
    m[2] = 32'h0604_0000;
    m[3] = 32'h0001_0010;
    m[7] = 32'h0000_0101;
    mIoV = 0; mIoB = 0; mIoE = 0; mMemV = 0; mMemB = 0; mMemE = 0;
  endtask

  task automatic checkWindows(input string tag);
    chk("R6", {tag, " ioValid"}, 32'(ioWinValid), 32'(mIoV));
    chk("R6", {tag, " ioBase"}, ioWinBase, mIoB);
    chk("R6", {tag, " ioEnd"}, ioWinEnd, mIoE);
    chk("R7", {tag, " memValid"}, 32'(memWinValid), 32'(mMemV));
    chk("R7", {tag, " memBase"}, memWinBase, mMemB);
    chk("R7", {tag, " memEnd"}, memWinEnd, mMemE);
    chk("R8", {tag, " secBus"}, 32'(secBus), 32'(m[6][15:8]));
  endtask

  // One access; checks the response against the model and the window timing.
  task automatic access(input bit we, input int idx, input logic [3:0] be,
                        input logic [31:0] wd, output logic [31:0] rd, output bit err);
    int lane;
    logic [31:0] wm, bm, expD;
    bit legal, expErr, ioTrig, memTrig;
    legal = legalBe(be, lane, wm);
    cfgValid = 1'b1; cfgWe = we; cfgDwAddr = 6'(idx); cfgByteEn = be; cfgWdata = wd;
    @(posedge clk);
    @(negedge clk);
    cfgValid = 1'b0;
    rd = rspData; err = rspErr;
    chk("R11", "response strobe", 32'(rspValid), 32'h1);
    ioTrig = 0; memTrig = 0;
    if (we) begin
      expErr = !legal;
      chk("R3", "write error flag", 32'(err), 32'(expErr));
      if (legal && implIdx(idx) && writableIdx(idx)) begin
        bm = wm << (8 * lane);
        m[idx] = (m[idx] & ~bm) | (((wd & wm) << (8 * lane)) & bm);
        if (idx == 7) m[idx] = m[idx] | 32'h0000_0101;
        ioTrig  = (idx == 7) || (idx == 12);
        memTrig = (idx == 8);
      end
    end else begin
      expErr = !legal || !implIdx(idx);
      expD = expErr ? 32'hFFFF_FFFF : ((m[idx] >> (8 * lane)) & wm);
      chk(legal ? "R4" : "R3", "read error flag", 32'(err), 32'(expErr));
      chk("R5", "read data", rd, expD);
    end
    checkWindows("R9 before update");
    if (ioTrig) begin
      mIoV = !((m[7][15:8] < m[7][7:0]) || (m[12][31:16] < m[12][15:0]));
      mIoB = mIoV ? {m[12][15:0], m[7][7:4], 12'h000} : 32'h0;
      mIoE = mIoV ? {m[12][31:16], m[7][15:12], 12'hFFF} : 32'h0;
    end
    if (memTrig) begin
      mMemV = !(m[8][31:16] < m[8][15:0]);
      mMemB = mMemV ? {m[8][15:4], 20'h00000} : 32'h0;
      mMemE = mMemV ? {m[8][31:20], 20'hFFFFF} : 32'h0;
    end
    @(posedge clk);
    @(negedge clk);
    checkWindows("R9 after update");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL R11 watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    bit err;
    logic [3:0] beTab [11];
    void'($urandom(32'd20240611));
    beTab = '{4'b1111, 4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0011,
              4'b0110, 4'b1100, 4'b0101, 4'b1001, 4'b0000};
    modelReset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    chk("R1", "secBus at reset", 32'(secBus), 32'h0);
    chk("R1", "ioValid at reset", 32'(ioWinValid), 32'h0);
    chk("R1", "memValid at reset", 32'(memWinValid), 32'h0);
    access(0, 0, 4'b1111, 0, rd, err);  chk("R1", "id dword", rd, 32'h7846_ABCD);
    access(0, 1, 4'b1111, 0, rd, err);  chk("R1", "status dword", rd, 32'h0010_0000);
    access(0, 2, 4'b1111, 0, rd, err);  chk("R1", "class dword", rd, 32'h0604_0000);
    access(0, 3, 4'b1111, 0, rd, err);  chk("R1", "header dword", rd, 32'h0001_0010);
    access(0, 7, 4'b1111, 0, rd, err);  chk("R1", "io dword", rd, 32'h0000_0101);
    access(0, 8, 4'b1111, 0, rd, err);  chk("R1", "mem dword", rd, 32'h0);

    // R2: type bits survive a write of zero
    access(1, 7, 4'b1111, 32'h0, rd, err);
    access(0, 7, 4'b1111, 0, rd, err);  chk("R2", "io type bits", rd, 32'h0000_0101);

    // R8, R5: byte write to the secondary bus lane
    access(1, 6, 4'b0010, 32'h0000_0005, rd, err);
    chk("R8", "secBus after write", 32'(secBus), 32'h05);
    access(0, 6, 4'b1111, 0, rd, err);  chk("R3", "merged bus dword", rd, 32'h0000_0500);
    access(0, 6, 4'b0010, 0, rd, err);  chk("R5", "byte read lane 1", rd, 32'h05);

    // R3: illegal pattern rejected, no change
    access(1, 6, 4'b0101, 32'hFFFF_FFFF, rd, err);
    chk("R3", "illegal be error", 32'(err), 32'h1);
    access(0, 6, 4'b1111, 0, rd, err);  chk("R3", "unchanged after reject", rd, 32'h0000_0500);

    // R4: holes and rom
    access(0, 13, 4'b1111, 0, rd, err);
    chk("R4", "hole data", rd, 32'hFFFF_FFFF); chk("R4", "hole err", 32'(err), 32'h1);
    access(0, 14, 4'b1111, 0, rd, err);  chk("R4", "rom reads zero", rd, 32'h0);
    access(1, 13, 4'b1111, 32'h1234, rd, err); chk("R4", "hole write no error", 32'(err), 32'h0);
    access(0, 40, 4'b1111, 0, rd, err);  chk("R4", "high index err", 32'(err), 32'h1);

    // R10: read-only dwords
    access(1, 0, 4'b1111, 32'h0, rd, err);
    access(0, 0, 4'b1111, 0, rd, err);  chk("R10", "id ignores write", rd, 32'h7846_ABCD);
    access(1, 3, 4'b0001, 32'h0, rd, err);
    access(0, 3, 4'b1111, 0, rd, err);  chk("R10", "header ignores write", rd, 32'h0001_0010);

    // R6: valid I/O window, then upper-half inversion
    access(1, 12, 4'b1111, 32'h0002_0001, rd, err);
    access(1, 7, 4'b0011, 32'h0000_3020, rd, err);
    chk("R6", "io valid", 32'(ioWinValid), 32'h1);
    chk("R6", "io base", ioWinBase, 32'h0001_2000);
    chk("R6", "io end", ioWinEnd, 32'h0002_3FFF);
    access(1, 12, 4'b1111, 32'h0001_0002, rd, err);
    chk("R6", "io upper inverted", 32'(ioWinValid), 32'h0);

    // R7: memory window and invalidation by narrow limit write
    access(1, 8, 4'b1111, 32'h0050_0010, rd, err);
    chk("R7", "mem valid", 32'(memWinValid), 32'h1);
    chk("R7", "mem base", memWinBase, 32'h0010_0000);
    chk("R7", "mem end", memWinEnd, 32'h005F_FFFF);
    access(1, 8, 4'b1100, 32'h0000_0000, rd, err);
    chk("R7", "mem invalid", 32'(memWinValid), 32'h0);

    // R5: two-byte read at lane 2
    access(0, 0, 4'b1100, 0, rd, err);  chk("R5", "half read lane 2", rd, 32'h0000_7846);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int idx;
      int sel;
      bit we;
      sel = int'($urandom % 4);
      idx = (sel == 0) ? 7 : (sel == 1) ? 8 : (sel == 2) ? 12 : int'($urandom % 20);
      we  = ($urandom % 3) != 0;
      access(we, idx, beTab[$urandom % 11], $urandom, rd, err);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule